// File: doc/BRIEF.md
# Full-Frame CCD Clock Sequencer

This block produces the logic-level clock phases that drive a full-frame CCD. The sensor has a three-phase vertical register, a transfer gate into a two-phase horizontal register, a reset-gate pulse and a summing-gate pulse. A single start request runs one complete frame. The frame is an integration interval, then a fixed number of line slots. Each slot holds a vertical transfer sequence and, for lines wanted by the user, a horizontal readout of every pixel period. The readout also marks which pixel periods carry image data.

Rows outside a programmable window of interest are dumped into the lateral drain. A dumped row gets its vertical transfer only, with both horizontal phases held high. The drain cannot empty the horizontal register completely. So the first wanted row after one or more dumped rows is preceded by a full horizontal pass that produces no valid pixels. In the low-dark-current integration mode, every clock output is held low for the whole integration interval.

All durations are counts of the system clock and are set by parameters. With a 250 MHz clock, the defaults give a 2 µs pixel period and a vertical sequence of about 20 µs. The defaults also give 1135 pixel periods per line (1130 of them active) and 330 line slots.

Top module: `ccd_seq`

## Requirements
- R1: After reset and while idle, v1_o is high and v2_o, v3_o, tg_o, h1_o, h2_o, rg_o, sg_o, pix_valid_o, line_end_o and frame_act_o are low.
- R2: A start_i seen while idle raises frame_act_o on the next cycle. The integration interval then lasts int_len_i+1 cycles (int_len_i of 0 gives one cycle). In normal mode the clocks keep their idle levels during integration.
- R3: With mode_mpp_i high at start, every clock output (v1, v2, v3, tg, h1, h2, rg, sg) is low for the whole integration interval.
- R4: Each line slot begins with six vertical segments, written as {v1,v2,v3,tg}. Segment 0 (VSET_CLKS cycles) is 1000, or 0000 for line 0 of a low-dark-current frame. Segments 1, 2 and 3 (VOVL_CLKS cycles each) are 1100, 0110 and 1010. Segment 4 (VSET_CLKS) is 1001. Segment 5 (VSET_CLKS) is 1000. v1 stays high and tg stays low during any horizontal pass.
- R5: A vertical output (v1, v2, v3, tg) never changes in the same cycle as h1_o or h2_o.
- R6: A readout pass is PIX_PER_LINE pixel periods of PIX_CLKS cycles each. In the first PIX_CLKS/2 cycles of a period, h1 is 1 and h2 is 0. In the rest, h1 is 0, h2 is 1 and sg is 1. rg is high for the first RG_CLKS cycles. During the vertical segments of a wanted line, {h1,h2} is 10 and rg and sg are 0.
- R7: pix_valid_o is high exactly during the first ACTIVE_PIX pixel periods of the readout of each line whose index lies in [roi_first_i, roi_last_i]. It is never high in overscan, clear-out or dumped lines.
- R8: A line outside the window gets only its six vertical segments, with {h1,h2} = 11 and no readout.
- R9: When a dumped line is followed by a wanted line, one full pass with the R6 waveform and pix_valid_o low runs before that wanted line's vertical segments.
- R10: line_end_o pulses for one cycle on the last cycle of each wanted line's readout. After LINES line slots, frame_act_o falls and the block is idle with R1 levels.
- R11: start_i, mode_mpp_i, int_len_i and the window inputs have no effect while a frame is in progress. They are sampled only with an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame request, accepted while idle |
| mode_mpp_i | input | 1 | 1 = hold all clocks low during integration |
| int_len_i | input | IW | Integration length minus one, in cycles |
| roi_first_i | input | LW | First line index to read |
| roi_last_i | input | LW | Last line index to read |
| v1_o | output | 1 | Vertical phase 1 |
| v2_o | output | 1 | Vertical phase 2 |
| v3_o | output | 1 | Vertical phase 3 |
| tg_o | output | 1 | Transfer gate |
| h1_o | output | 1 | Horizontal phase 1 |
| h2_o | output | 1 | Horizontal phase 2 |
| rg_o | output | 1 | Reset gate pulse |
| sg_o | output | 1 | Summing gate pulse |
| pix_valid_o | output | 1 | Current pixel period carries image data |
| line_end_o | output | 1 | Last cycle of a wanted line |
| frame_act_o | output | 1 | Frame in progress |

## Verification
All outputs are decoded directly from registers. Every result therefore appears in the first cycle after the clock edge that moves the state. frame_act_o and the integration levels are visible one cycle after the edge that samples start_i. Each later segment or pixel period follows back to back, with no gap cycles. The bench builds the expected waveform of a whole frame, cycle by cycle, from the requirement timings. It drives start at a falling edge and compares every following falling-edge sample against that list. The sample after the last entry must show the idle levels. Separate counts of pixel-valid cycles, line-end pulses and vertical-with-horizontal edges are checked at the end of each frame.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INTEG,
    ST_CLEAR,
    ST_VSHIFT,
    ST_HREAD
  } seq_state_t;

  typedef struct packed {
    logic v1;
    logic v2;
    logic v3;
    logic tg;
    logic h1;
    logic h2;
    logic rg;
    logic sg;
  } ccd_clk_t;

endpackage

// File: rtl/ccd_cnt.sv
module ccd_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] q
);

  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (clr)     q_d = '0;
    else if (en) q_d = q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

endmodule

// File: rtl/ccd_phase.sv
module ccd_phase
  import ccd_seq_pkg::*;
#(
  parameter int CW       = 8,
  parameter int PIX_CLKS = 4,
  parameter int RG_CLKS  = 1
) (
  input  seq_state_t    state,
  input  logic          mpp,
  input  logic          hold_low,
  input  logic          skip,
  input  logic [2:0]    seg,
  input  logic [CW-1:0] cyc,
  output ccd_clk_t      ph
);

  logic first_half;
  assign first_half = cyc < CW'(PIX_CLKS / 2);

  always_comb begin
    ph    = '0;
    ph.v1 = 1'b1;
    unique case (state)
      ST_IDLE: ;
      ST_INTEG: begin
        if (mpp) ph = '0;
      end
      ST_VSHIFT: begin
        ph.h1 = 1'b1;
        ph.h2 = skip;
        case (seg)
          3'd0: ph.v1 = !hold_low;
          3'd1: ph.v2 = 1'b1;
          3'd2: begin
            ph.v1 = 1'b0;
            ph.v2 = 1'b1;
            ph.v3 = 1'b1;
          end
          3'd3: ph.v3 = 1'b1;
          3'd4: ph.tg = 1'b1;
          default: ;
        endcase
      end
      ST_CLEAR, ST_HREAD: begin
        ph.h1 = first_half;
        ph.h2 = !first_half;
        ph.sg = !first_half;
        ph.rg = cyc < CW'(RG_CLKS);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ccd_seq.sv
module ccd_seq
  import ccd_seq_pkg::*;
#(
  parameter int LINES        = 330,
  parameter int PIX_PER_LINE = 1135,
  parameter int ACTIVE_PIX   = 1130,
  parameter int PIX_CLKS     = 500,
  parameter int RG_CLKS      = 50,
  parameter int VOVL_CLKS    = 1260,
  parameter int VSET_CLKS    = 406,
  parameter int IW           = 24,
  localparam int LW = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          mode_mpp_i,
  input  logic [IW-1:0] int_len_i,
  input  logic [LW-1:0] roi_first_i,
  input  logic [LW-1:0] roi_last_i,
  output logic          v1_o,
  output logic          v2_o,
  output logic          v3_o,
  output logic          tg_o,
  output logic          h1_o,
  output logic          h2_o,
  output logic          rg_o,
  output logic          sg_o,
  output logic          pix_valid_o,
  output logic          line_end_o,
  output logic          frame_act_o
);

  localparam int CP  = $clog2(PIX_CLKS);
  localparam int CV  = $clog2((VOVL_CLKS > VSET_CLKS) ? VOVL_CLKS : VSET_CLKS);
  localparam int CH  = (CP > CV) ? CP : CV;
  localparam int CW  = (CH > IW) ? CH : IW;
  localparam int UP  = $clog2(PIX_PER_LINE);
  localparam int UW  = (UP > 3) ? UP : 3;

  seq_state_t    state_q, state_d;
  logic          mpp_q;
  logic [IW-1:0] ilen_q;
  logic [LW-1:0] first_q, last_q;
  logic          load;
  logic          line_inc;
  logic          cyc_end, phase_end;
  logic [CW-1:0] cyc_q, seg_last;
  logic [UW-1:0] unit_q;
  logic [LW-1:0] line_q, line_nx;
  logic          roi_cur, roi_nxt, line_is_last;
  ccd_clk_t      ph;

  // counters: cycle within unit, unit (segment or pixel), line slot
  ccd_cnt #(.W(CW)) u_cyc (
    .clk(clk), .rst_n(rst_n),
    .clr(cyc_end || state_q == ST_IDLE), .en(1'b1), .q(cyc_q)
  );
  ccd_cnt #(.W(UW)) u_unit (
    .clk(clk), .rst_n(rst_n),
    .clr(phase_end || state_q == ST_IDLE), .en(cyc_end), .q(unit_q)
  );
  ccd_cnt #(.W(LW)) u_line (
    .clk(clk), .rst_n(rst_n),
    .clr(load), .en(line_inc), .q(line_q)
  );

  assign line_nx      = line_q + LW'(1);
  assign roi_cur      = (line_q >= first_q) && (line_q <= last_q);
  assign roi_nxt      = (line_nx >= first_q) && (line_nx <= last_q);
  assign line_is_last = line_q == LW'(LINES - 1);
  assign seg_last     = (unit_q >= UW'(1) && unit_q <= UW'(3)) ?
                        CW'(VOVL_CLKS - 1) : CW'(VSET_CLKS - 1);

  always_comb begin
    cyc_end   = 1'b0;
    phase_end = 1'b0;
    unique case (state_q)
      ST_INTEG: begin
        cyc_end   = cyc_q == CW'(ilen_q);
        phase_end = cyc_end;
      end
      ST_VSHIFT: begin
        cyc_end   = cyc_q == seg_last;
        phase_end = cyc_end && unit_q == UW'(5);
      end
      ST_CLEAR, ST_HREAD: begin
        cyc_end   = cyc_q == CW'(PIX_CLKS - 1);
        phase_end = cyc_end && unit_q == UW'(PIX_PER_LINE - 1);
      end
      default: ;
    endcase
  end

  // next state
  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    line_inc = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_INTEG;
          load    = 1'b1;
        end
      end
      ST_INTEG: begin
        if (phase_end) state_d = ST_VSHIFT;
      end
      ST_VSHIFT: begin
        if (phase_end) begin
          if (roi_cur)           state_d = ST_HREAD;
          else if (line_is_last) state_d = ST_IDLE;
          else begin
            line_inc = 1'b1;
            state_d  = roi_nxt ? ST_CLEAR : ST_VSHIFT;
          end
        end
      end
      ST_HREAD: begin
        if (phase_end) begin
          if (line_is_last) state_d = ST_IDLE;
          else begin
            line_inc = 1'b1;
            state_d  = ST_VSHIFT;
          end
        end
      end
      ST_CLEAR: begin
        if (phase_end) state_d = ST_VSHIFT;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mpp_q   <= 1'b0;
      ilen_q  <= '0;
      first_q <= '0;
      last_q  <= '0;
    end else if (load) begin
      mpp_q   <= mode_mpp_i;
      ilen_q  <= int_len_i;
      first_q <= roi_first_i;
      last_q  <= roi_last_i;
    end
  end

  ccd_phase #(.CW(CW), .PIX_CLKS(PIX_CLKS), .RG_CLKS(RG_CLKS)) u_phase (
    .state   (state_q),
    .mpp     (mpp_q),
    .hold_low(mpp_q && line_q == '0),
    .skip    (!roi_cur),
    .seg     (unit_q[2:0]),
    .cyc     (cyc_q),
    .ph      (ph)
  );

  assign v1_o        = ph.v1;
  assign v2_o        = ph.v2;
  assign v3_o        = ph.v3;
  assign tg_o        = ph.tg;
  assign h1_o        = ph.h1;
  assign h2_o        = ph.h2;
  assign rg_o        = ph.rg;
  assign sg_o        = ph.sg;
  assign pix_valid_o = state_q == ST_HREAD && unit_q < UW'(ACTIVE_PIX);
  assign line_end_o  = state_q == ST_HREAD && phase_end;
  assign frame_act_o = state_q != ST_IDLE;

endmodule

// File: rtl/ccd_seq_chk.sv
module ccd_seq_chk
  import ccd_seq_pkg::*;
#(
  parameter int LW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input seq_state_t    state,
  input logic          mpp,
  input logic [LW-1:0] line,
  input logic [LW-1:0] first,
  input logic [LW-1:0] last,
  input logic          start,
  input logic          v1, v2, v3, tg,
  input logic          h1, h2, rg, sg,
  input logic          pv
);

  AST_V_H_APART: assert property (@(posedge clk) disable iff (!rst_n)
    ({v1, v2, v3, tg} != $past({v1, v2, v3, tg})) |-> ({h1, h2} == $past({h1, h2}))); // R5

  AST_MPP_ALL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_INTEG && mpp) |-> ({v1, v2, v3, tg, h1, h2, rg, sg} == 8'h00)); // R3

  AST_PV_IN_ROI: assert property (@(posedge clk) disable iff (!rst_n)
    pv |-> (line >= first && line <= last && state == ST_HREAD)); // R7

  AST_SKIP_H_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_VSHIFT && !(line >= first && line <= last)) |-> (h1 && h2)); // R8

  AST_NO_TRIPLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(v1 && v2 && v3)); // R4

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> ($stable(first) && $stable(last) && $stable(mpp))); // R11

endmodule

bind ccd_seq ccd_seq_chk #(.LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .state(state_q), .mpp(mpp_q),
  .line(line_q), .first(first_q), .last(last_q), .start(start_i),
  .v1(v1_o), .v2(v2_o), .v3(v3_o), .tg(tg_o),
  .h1(h1_o), .h2(h2_o), .rg(rg_o), .sg(sg_o), .pv(pix_valid_o)
);

// File: tb/ccd_seq_bench.sv
module ccd_seq_bench;

  localparam int LINES = 5;
  localparam int PPL   = 6;
  localparam int ACT   = 4;
  localparam int PIX   = 4;
  localparam int RG    = 1;
  localparam int VOVL  = 3;
  localparam int VSET  = 2;
  localparam int IW    = 8;
  localparam int LW    = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic start, mpp;
  logic [IW-1:0] ilen;
  logic [LW-1:0] first, last;
  logic v1, v2, v3, tg, h1, h2, rg, sg, pv, le, fa;

  int checks = 0;
  int errors = 0;
  int vh_bad = 0;

  logic [10:0] exp_q[$];
  int          exp_tag[$];

  always #2 clk = ~clk;

  ccd_seq #(
    .LINES(LINES), .PIX_PER_LINE(PPL), .ACTIVE_PIX(ACT), .PIX_CLKS(PIX),
    .RG_CLKS(RG), .VOVL_CLKS(VOVL), .VSET_CLKS(VSET), .IW(IW)
  ) u_ccd_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mode_mpp_i(mpp),
    .int_len_i(ilen), .roi_first_i(first), .roi_last_i(last),
    .v1_o(v1), .v2_o(v2), .v3_o(v3), .tg_o(tg), .h1_o(h1), .h2_o(h2),
    .rg_o(rg), .sg_o(sg), .pix_valid_o(pv), .line_end_o(le), .frame_act_o(fa)
  );

  function automatic logic [10:0] obs();
    return {v1, v2, v3, tg, h1, h2, rg, sg, pv, le, fa};
  endfunction

  function automatic string tag_name(int c);
    case (c)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      9: return "R9";
      10: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // R5 monitor: vertical and horizontal edges on the same cycle
  logic [3:0] pv_v;
  logic [1:0] pv_h;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pv_v != {v1, v2, v3, tg} && pv_h != {h1, h2}) vh_bad++;
    end
    pv_v = {v1, v2, v3, tg};
    pv_h = {h1, h2};
  end

  task automatic push(logic [3:0] v, logic [1:0] h, logic r, logic s,
                      logic p, logic l, logic f, int tag);
    exp_q.push_back({v, h, r, s, p, l, f});
    exp_tag.push_back(tag);
  endtask

  task automatic push_pass(bit valid);
    for (int p = 0; p < PPL; p++)
      for (int c = 0; c < PIX; c++) begin
        logic fh = c < PIX / 2;
        logic pvx = valid && (p < ACT);
        logic lex = valid && (p == PPL - 1) && (c == PIX - 1);
        push(4'b1000, fh ? 2'b10 : 2'b01, c < RG, !fh, pvx, lex, 1'b1,
             !valid ? 9 : (lex ? 10 : (pvx ? 7 : 6)));
      end
  endtask

  task automatic build(bit m, int f, int l, int il);
    bit prev_skip = 0;
    exp_q.delete();
    exp_tag.delete();
    for (int i = 0; i <= il; i++)
      push(m ? 4'b0000 : 4'b1000, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, m ? 3 : 2);
    for (int ln = 0; ln < LINES; ln++) begin
      bit roi = (ln >= f) && (ln <= l);
      logic [1:0] hq = roi ? 2'b10 : 2'b11;
      int tg_t = roi ? 4 : 8;
      if (roi && prev_skip) push_pass(1'b0);
      for (int s = 0; s < 6; s++) begin
        int len = (s >= 1 && s <= 3) ? VOVL : VSET;
        logic [3:0] vv;
        case (s)
          0: vv = (m && ln == 0) ? 4'b0000 : 4'b1000;
          1: vv = 4'b1100;
          2: vv = 4'b0110;
          3: vv = 4'b1010;
          4: vv = 4'b1001;
          default: vv = 4'b1000;
        endcase
        for (int c = 0; c < len; c++)
          push(vv, hq, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, tg_t);
      end
      if (roi) push_pass(1'b1);
      prev_skip = !roi;
    end
    push(4'b1000, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10);
  endtask

  task automatic run_frame(bit m, int f, int l, int il, bit poke);
    int nroi = 0;
    int pv_cnt = 0;
    int le_cnt = 0;
    int bad = 0;
    for (int ln = 0; ln < LINES; ln++) if (ln >= f && ln <= l) nroi++;
    build(m, f, l, il);
    @(negedge clk);
    mpp = m; first = LW'(f); last = LW'(l); ilen = IW'(il); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < exp_q.size(); k++) begin
      if (k > 0) @(negedge clk);
      checks++;
      if (obs() !== exp_q[k]) begin
        errors++;
        bad++;
        if (bad <= 8)
          $display("FAIL %s cycle %0d actual=%b expected=%b",
                   tag_name(exp_tag[k]), k, obs(), exp_q[k]);
      end
      if (pv) pv_cnt++;
      if (le) le_cnt++;
      if (poke && k == 5) begin
        // R11: request and configuration changes inside a frame
        start = 1'b1; mpp = !m; first = '0; last = LW'(LINES - 1); ilen = '0;
      end
      if (poke && k == 6) start = 1'b0;
    end
    check(pv_cnt == nroi * ACT * PIX, "R7", pv_cnt, nroi * ACT * PIX);
    check(le_cnt == nroi, "R10", le_cnt, nroi);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(fa == 1'b0, "R11", fa, 0);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; mpp = 1'b0; ilen = '0; first = '0; last = '0;
    repeat (3) @(negedge clk);
    check(obs() == 11'b1000_0000_000, "R1", obs(), 11'b1000_0000_000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(obs() == 11'b1000_0000_000, "R1", obs(), 11'b1000_0000_000);
  endtask

  task automatic t_normal();     // R2 R4 R6 R7 R10
    run_frame(1'b0, 0, LINES - 1, 3, 1'b0);
  endtask

  task automatic t_mpp();        // R3, one-cycle integration boundary R2
    run_frame(1'b1, 0, LINES - 1, 0, 1'b0);
  endtask

  task automatic t_window();     // R8 R9 with mid-frame requests R11
    run_frame(1'b0, 2, 3, 2, 1'b1);
  endtask

  task automatic t_single_mpp(); // R8 R9 with dumped line 0 in R3 mode
    run_frame(1'b1, 1, 1, 1, 1'b0);
  endtask

  task automatic t_all_dumped(); // R8: no wanted line, no clear-out
    run_frame(1'b0, 4, 0, 1, 1'b0);
  endtask

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_normal();
    t_mpp();
    t_window();
    t_single_mpp();
    t_all_dumped();
    check(vh_bad == 0, "R5", vh_bad, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule